// File: doc/BRIEF.md
# USB Device Port Interrupt Status Aggregator

This block collects event pulses from the logic of a USB device port and turns them into one level-sensitive interrupt line for firmware. Each event source has a sticky status bit. Firmware reads the status through a small 32-bit register bus. It acknowledges an event by writing a 1 to that bit's position. A separate enable register decides which status bits may raise the interrupt.

Status is held on two levels. Twenty-one endpoints each report an acknowledge event into a dedicated endpoint status register, which has its own enable register. The masked OR of those endpoint bits appears as one read-only summary bit in the main status register. Firmware sees a single summary flag in the main register and then reads the endpoint register to find out which endpoint needs service. The summary bit goes low only once every enabled endpoint bit has been cleared.

The bus has an address, a write strobe, write data and read data. Writes take effect at the clock edge. Reads are combinational from the current address. The interrupt output is registered.

Top module: `usb_irq_aggregator`

## Requirements
- R1: After reset, every register reads 0 and `irqOut` is 0.
- R2: A one-cycle pulse on `mainEvt[i]`, for any i other than 16, sets bit i of the main status register at offset 0x0C. The bit reads as 1 from the next cycle on and stays set until firmware clears it.
- R3: Writing offset 0x0C clears each sticky status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: When an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set. This applies to both the main register and the endpoint register.
- R5: The endpoint status register at offset 0x18 holds 21 bits, and bit i belongs to endpoint i+1. A pulse on `epAckEvt[i]` sets bit i. Writing 1 to bit i at 0x18 clears that bit only.
- R6: The main enable register at 0x08 stores write-data bits 17:0. The endpoint enable register at 0x10 stores bits 20:0. Both read back what was stored, and all bits above the stored width read 0 in all four mapped registers.
- R7: Bit 16 of the main status register reads as the OR over all endpoints of (endpoint status AND endpoint enable). Writing bit 16 at 0x0C has no effect, and neither does `mainEvt[16]`.
- R8: `irqOut` is the OR of (main status as read, including bit 16, AND main enable), delayed by one register. It changes one clock edge after the status or enable change becomes visible on a read.
- R9: Any offset other than 0x08, 0x0C, 0x10 and 0x18 reads 0. This includes the unimplemented endpoint NAK offsets 0x14 and 0x1C. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe for the addressed register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| mainEvt | input | 18 | Event pulses for the main status bits; bit 16 is ignored |
| epAckEvt | input | 21 | Acknowledge event pulses; bit i belongs to endpoint i+1 |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The bench goes after the same-cycle collision of an event with a write-1 clear. A design that let the clear win would silently lose an event that arrived during acknowledgement. It also targets the summary bit. A design that stored bit 16 as an ordinary sticky bit, or honoured writes to it, would leave the summary set after the endpoint bits were cleared, or drop it while endpoints still wait for service. The interrupt delay is checked to the exact cycle, so combinational or doubly registered paths show up. Writes to unmapped offsets, such as the NAK offsets, are followed by readbacks of every real register, to catch decoding that aliases those offsets onto a real register.

// File: rtl/usb_irq_pkg.sv
`timescale 1ns/1ps
package usb_irq_pkg;
  localparam int unsigned BUS_AW  = 8;
  localparam int unsigned BUS_DW  = 32;
  localparam int unsigned MAIN_W  = 18;
  localparam int unsigned EP_W    = 21;
  localparam int unsigned SUM_POS = 16;

  localparam logic [BUS_AW-1:0] OFF_MAIN_EN  = 8'h08;
  localparam logic [BUS_AW-1:0] OFF_MAIN_STS = 8'h0C;
  localparam logic [BUS_AW-1:0] OFF_EP_EN    = 8'h10;
  localparam logic [BUS_AW-1:0] OFF_EP_STS   = 8'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MAIN_EN,
    SEL_MAIN_STS,
    SEL_EP_EN,
    SEL_EP_STS
  } regSel_e;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic    wrMainEn;
    logic    clrMainSts;
    logic    wrEpEn;
    logic    clrEpSts;
    regSel_e rdSel;
  } busStrobe_t;
endpackage

// File: rtl/usb_irq_ctrl.sv
`timescale 1ns/1ps
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int unsigned AW = BUS_AW,
  parameter int unsigned PW = MAIN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic [PW-1:0] pendVec,
  output busStrobe_t    strobe,
  output logic          irqOut
);
  regSel_e sel;

  always_comb begin
    case (busAddr)
      OFF_MAIN_EN:  sel = SEL_MAIN_EN;
      OFF_MAIN_STS: sel = SEL_MAIN_STS;
      OFF_EP_EN:    sel = SEL_EP_EN;
      OFF_EP_STS:   sel = SEL_EP_STS;
      default:      sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.rdSel      = sel;
    strobe.wrMainEn   = busWe && (sel == SEL_MAIN_EN);
    strobe.clrMainSts = busWe && (sel == SEL_MAIN_STS);
    strobe.wrEpEn     = busWe && (sel == SEL_EP_EN);
    strobe.clrEpSts   = busWe && (sel == SEL_EP_STS);
  end

  // One register stage between the pending bits and the interrupt pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |pendVec;
  end
endmodule

// File: rtl/usb_irq_datapath.sv
`timescale 1ns/1ps
module usb_irq_datapath
  import usb_irq_pkg::*;
#(
  parameter int unsigned DW = BUS_DW,
  parameter int unsigned MW = MAIN_W,
  parameter int unsigned EW = EP_W,
  parameter int unsigned SP = SUM_POS
) (
  input  logic          clk,
  input  logic          rstN,
  input  busStrobe_t    strobe,
  input  logic [DW-1:0] busWdata,
  input  logic [MW-1:0] mainEvt,
  input  logic [EW-1:0] epAckEvt,
  output logic [DW-1:0] busRdata,
  output logic [MW-1:0] pendVec
);
  localparam logic [MW-1:0] STICKY_MASK = ~(MW'(1) << SP);

  logic [MW-1:0] mainStsQ, mainEnQ, mainVis, mainClr;
  logic [EW-1:0] epStsQ, epEnQ, epClr;
  logic          epSum;
  logic          unusedWdataHigh;

  assign unusedWdataHigh = ^busWdata[DW-1:EW];

  assign mainClr = strobe.clrMainSts ? busWdata[MW-1:0] : '0;
  assign epClr   = strobe.clrEpSts   ? busWdata[EW-1:0] : '0;

  assign epSum   = |(epStsQ & epEnQ);
  assign mainVis = (mainStsQ & STICKY_MASK) | (MW'(epSum) << SP);
  assign pendVec = mainVis & mainEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainStsQ <= '0;
      mainEnQ  <= '0;
      epStsQ   <= '0;
      epEnQ    <= '0;
    end else begin
      // Clear first, then OR in new events: an event is never lost
      mainStsQ <= ((mainStsQ & ~mainClr) | mainEvt) & STICKY_MASK;
      epStsQ   <= (epStsQ & ~epClr) | epAckEvt;
      if (strobe.wrMainEn) mainEnQ <= busWdata[MW-1:0];
      if (strobe.wrEpEn)   epEnQ   <= busWdata[EW-1:0];
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_MAIN_EN:  busRdata = DW'(mainEnQ);
      SEL_MAIN_STS: busRdata = DW'(mainVis);
      SEL_EP_EN:    busRdata = DW'(epEnQ);
      SEL_EP_STS:   busRdata = DW'(epStsQ);
      default:      busRdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_irq_aggregator.sv
`timescale 1ns/1ps
module usb_irq_aggregator
  import usb_irq_pkg::*;
#(
  parameter int unsigned AW = BUS_AW,
  parameter int unsigned DW = BUS_DW,
  parameter int unsigned MW = MAIN_W,
  parameter int unsigned EW = EP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  input  logic [MW-1:0] mainEvt,
  input  logic [EW-1:0] epAckEvt,
  output logic          irqOut
);
  busStrobe_t    strobe;
  logic [MW-1:0] pendVec;

  usb_irq_ctrl #(.AW(AW), .PW(MW)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .pendVec (pendVec),
    .strobe  (strobe),
    .irqOut  (irqOut)
  );

  usb_irq_datapath #(.DW(DW), .MW(MW), .EW(EW), .SP(SUM_POS)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .mainEvt  (mainEvt),
    .epAckEvt (epAckEvt),
    .busRdata (busRdata),
    .pendVec  (pendVec)
  );
endmodule

// File: rtl/usb_irq_checker.sv
`timescale 1ns/1ps
module usb_irq_checker
  import usb_irq_pkg::*;
#(
  parameter int unsigned AW = BUS_AW,
  parameter int unsigned DW = BUS_DW,
  parameter int unsigned MW = MAIN_W,
  parameter int unsigned EW = EP_W
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] busAddr,
  input logic          busWe,
  input logic [DW-1:0] busWdata,
  input logic [DW-1:0] busRdata,
  input logic [MW-1:0] mainEvt,
  input logic [EW-1:0] epAckEvt,
  input logic          irqOut,
  input logic [MW-1:0] pendVec
);
  localparam logic [MW-1:0] STICKY = ~(MW'(1) << SUM_POS);

  logic isMapped;
  assign isMapped = (busAddr == OFF_MAIN_EN) || (busAddr == OFF_MAIN_STS) ||
                    (busAddr == OFF_EP_EN) || (busAddr == OFF_EP_STS);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(|pendVec) |-> irqOut);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|pendVec) |-> !irqOut);

  assert_main_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFF_MAIN_STS) |->
      ((busRdata[MW-1:0] & $past(mainEvt & STICKY)) == $past(mainEvt & STICKY)));

  assert_ep_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFF_EP_STS) |->
      ((busRdata[EW-1:0] & $past(epAckEvt)) == $past(epAckEvt)));

  assert_main_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((busAddr == OFF_MAIN_STS) && $past(busWe && (busAddr == OFF_MAIN_STS))) |->
      ((busRdata[MW-1:0] & STICKY & $past(busWdata[MW-1:0] & ~mainEvt)) == '0));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped |-> (busRdata == '0));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    isMapped |-> (busRdata[DW-1:EW] == '0));
endmodule

bind usb_irq_aggregator usb_irq_checker i_chk (.*);

// File: tb/test_usb_irq_aggregator.sv
`timescale 1ns/1ps
module test_usb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [17:0] mainEvt = '0;
  logic [20:0] epAckEvt = '0;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Bench model of the registers and the interrupt flop
  logic [17:0] mSts = '0, mEn = '0;
  logic [20:0] eSts = '0, eEn = '0;
  logic        irqM = 1'b0;

  always #10 clk = ~clk;

  usb_irq_aggregator i_usb_irq_aggregator (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .mainEvt(mainEvt),
    .epAckEvt(epAckEvt), .irqOut(irqOut)
  );

  function automatic logic [17:0] mainVisM();
    logic [17:0] v;
    v = mSts & ~18'h10000;
    v[16] = |(eSts & eEn);
    return v;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h08:   return {14'b0, mEn};
      8'h0C:   return {14'b0, mainVisM()};
      8'h10:   return {11'b0, eEn};
      8'h18:   return {11'b0, eSts};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic we, input logic [31:0] wd,
                      input logic [17:0] me, input logic [20:0] ee, input string tag);
    @(negedge clk);
    busAddr = a; busWe = we; busWdata = wd; mainEvt = me; epAckEvt = ee;
    #1;
    if (!we) check(tag, busRdata, expRead(a));
    check({tag, " irq"}, {31'b0, irqOut}, {31'b0, irqM});
    @(posedge clk);
    irqM = |(mainVisM() & mEn);
    if (we) begin
      case (a)
        8'h08: mEn = wd[17:0];
        8'h0C: mSts = mSts & ~wd[17:0];
        8'h10: eEn = wd[20:0];
        8'h18: eSts = eSts & ~wd[20:0];
        default: ;
      endcase
    end
    mSts = (mSts | me) & ~18'h10000;
    eSts = eSts | ee;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(a, 1'b0, 32'h0, '0, '0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(a, 1'b1, d, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [8];
    addrs = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h04};
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(8'h08, "R1"); rd(8'h0C, "R1"); rd(8'h10, "R1"); rd(8'h18, "R1");

    // R6: enable registers store their width only
    wr(8'h08, 32'hFFFF_FFFF, "R6"); rd(8'h08, "R6");
    wr(8'h10, 32'hFFFF_FFFF, "R6"); rd(8'h10, "R6");
    wr(8'h08, 32'h0, "R6"); wr(8'h10, 32'h0, "R6"); rd(8'h08, "R6");

    // R2: sticky main bits
    step(8'h0C, 1'b0, 32'h0, 18'h00201, '0, "R2");
    rd(8'h0C, "R2"); rd(8'h0C, "R2");

    // R3: write 1 clears, write 0 keeps
    wr(8'h0C, 32'h1, "R3"); rd(8'h0C, "R3");
    wr(8'h0C, 32'h0, "R3"); rd(8'h0C, "R3");

    // R4: set wins over same-cycle clear, main and endpoint
    step(8'h0C, 1'b1, 32'h200, 18'h00200, '0, "R4"); rd(8'h0C, "R4");
    step(8'h18, 1'b1, 32'h8, '0, 21'h8, "R4"); rd(8'h18, "R4");

    // R7: summary bit behaviour
    step(8'h0C, 1'b0, 32'h0, 18'h10000, '0, "R7"); rd(8'h0C, "R7");
    step(8'h18, 1'b0, 32'h0, '0, 21'h100000, "R7"); rd(8'h0C, "R7");
    wr(8'h10, 32'h100000, "R7"); rd(8'h0C, "R7");
    wr(8'h0C, 32'h10000, "R7"); rd(8'h0C, "R7");
    wr(8'h18, 32'h100000, "R7"); rd(8'h0C, "R7");

    // R5: per-endpoint clear
    step(8'h18, 1'b0, 32'h0, '0, 21'h21, "R5"); rd(8'h18, "R5");
    wr(8'h18, 32'h1, "R5"); rd(8'h18, "R5");

    // R8: interrupt latency from enable and from summary
    wr(8'h08, 32'h200, "R8"); rd(8'h0C, "R8"); rd(8'h0C, "R8");
    wr(8'h0C, 32'h200, "R8"); rd(8'h0C, "R8"); rd(8'h0C, "R8");
    wr(8'h08, 32'h10000, "R8"); wr(8'h10, 32'h20, "R8"); rd(8'h0C, "R8"); rd(8'h0C, "R8");
    wr(8'h18, 32'h28, "R8"); rd(8'h0C, "R8"); rd(8'h0C, "R8");

    // R9: unmapped offsets read zero and touch nothing
    wr(8'h08, 32'h3, "R9"); step(8'h0C, 1'b0, 32'h0, 18'h2, 21'h4, "R9");
    wr(8'h14, 32'hFFFF_FFFF, "R9"); wr(8'h1C, 32'hFFFF_FFFF, "R9");
    wr(8'h00, 32'hFFFF_FFFF, "R9"); wr(8'h04, 32'hFFFF_FFFF, "R9");
    rd(8'h14, "R9"); rd(8'h1C, "R9"); rd(8'h00, "R9");
    rd(8'h08, "R9"); rd(8'h0C, "R9"); rd(8'h10, "R9"); rd(8'h18, "R9");

    // Random mix covering R2, R3, R4, R5, R7 and R8 together
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a;
      logic        we;
      logic [31:0] wd;
      logic [17:0] me;
      logic [20:0] ee;
      a  = addrs[$urandom_range(7, 0)];
      we = ($urandom_range(3, 0) == 0);
      wd = $urandom();
      me = 18'($urandom() & $urandom() & $urandom());
      ee = 21'($urandom() & $urandom() & $urandom());
      step(a, we, wd, me, ee, "random R2/R3/R5/R8");
    end

    rd(8'h0C, "R8"); rd(8'h18, "R5");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule